// File: doc/BRIEF.md
# Multi-Level Tagged Translation Cache

This block holds finished address translations for an I/O memory management unit so that a device access can skip the page-table walk when the same mapping was resolved earlier. Each of the sixteen fully associative slots records the address-space identifier, the virtual-machine identifier, the size-aligned input address, the translation granule code and the table level at which the walk ended. The slot also records what the walk produced: the output address, the span mask, the permission bits, the level and the granule.

A lookup does not know in advance at which level the mapping was found. It therefore probes the stored tags level by level, one level per clock. It starts at the shallowest level that the table size allows and stops at the first match or after level 3. At every level the input address is cut down to the span of that level before the compare. The walker writes results through the insert port. Software maintenance reaches the cache through one invalidation port. That port can drop everything, drop all slots of one address space, drop all slots of one virtual machine, or drop the slots touched by an address range. In the range form either identifier may be a wildcard, and a form with a level hint first tries to remove one exact tag. Two free-running counters record the outcome of every lookup.

Top module: `iotlb_cache`

## Requirements
- R1: A probe hits only when one valid slot matches all five tag fields: identifier `asid`, identifier `vmid`, level-aligned address, granule code (1 = 4 KB, 2 = 16 KB, 3 = 64 KB) and level. The hit response returns that slot's output address, span mask, permission bits, level and granule.
- R2: The first probed level is 4 − (insize − 4) / stride, with insize = 64 − `lk_tsz` and stride = log2(granule) − 3, held to the range 0..3. Levels are probed in rising order, one per clock, and the response pulse comes N clocks after the accept edge when the search ends on the Nth probe (4 KB with `lk_tsz`=16 starts at level 0; 64 KB with `lk_tsz`=16 starts at level 1).
- R3: At a probe of level L the lookup address has its low log2(granule)+(log2(granule)−3)·(3−L) bits cleared before the compare, so any offset inside a stored page or block still hits.
- R4: `lk_ready` is low from the accept edge until the response. `rsp_valid` is a single-clock pulse, and `lk_ready` is high in that cycle.
- R5: An insert into a cache that has a free slot keeps every existing slot. An insert into a cache whose 16 slots are all valid first empties the cache and then stores the new entry alone.
- R6: Invalidation op 0 empties the cache.
- R7: Invalidation op 1 removes every slot whose `asid` equals `inv_asid` and no other slot.
- R8: Invalidation op 2 removes every slot whose `vmid` equals `inv_vmid` and no other slot.
- R9: Invalidation op 3 (range) builds cmd_mask = (`inv_pages` << log2(granule)) − 1, where `inv_gran` 0 means 4 KB. It removes a slot whose identifiers match (a set `inv_asid_any` / `inv_vmid_any` skips that compare) when (cmd_addr & ~slot_mask) == slot_addr or when (slot_addr & ~cmd_mask) == cmd_addr.
- R10: When op 3 has `inv_ttl` ≠ 0, `inv_pages` = 1 and neither wildcard, only a slot whose full tag equals the command's (level = `inv_ttl`) is removed. The range rule of R9 applies only when no such slot exists.
- R11: `hit_count` rises by one on each hit response and `miss_count` rises by one on each miss response. Neither counter changes at any other time.
- R12: A probe compares against the contents held before any same-clock invalidation. An insert in the same clock as an invalidation is written after the removal and survives it.
- R13: After reset the cache is empty, `lk_ready` is high, `rsp_valid` is low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_asid | input | 16 | Lookup address-space identifier |
| lk_vmid | input | 16 | Lookup virtual-machine identifier |
| lk_addr | input | 48 | Lookup input address |
| lk_gran | input | 2 | Lookup granule code |
| lk_tsz | input | 6 | Table size field selecting the start level |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response is a hit |
| rsp_oaddr | output | 48 | Output address of the hit slot |
| rsp_mask | output | 48 | Span mask of the hit slot |
| rsp_perm | output | 2 | Permission bits of the hit slot |
| rsp_level | output | 2 | Level of the hit slot |
| rsp_gran | output | 2 | Granule code of the hit slot |
| ins_valid | input | 1 | Insert strobe |
| ins_asid | input | 16 | Insert address-space identifier |
| ins_vmid | input | 16 | Insert virtual-machine identifier |
| ins_addr | input | 48 | Insert input address (aligned on write) |
| ins_gran | input | 2 | Insert granule code |
| ins_level | input | 2 | Insert level |
| ins_oaddr | input | 48 | Insert output address |
| ins_perm | input | 2 | Insert permission bits |
| inv_valid | input | 1 | Invalidation strobe |
| inv_op | input | 2 | 0 all, 1 by asid, 2 by vmid, 3 range |
| inv_asid | input | 16 | Invalidation address-space identifier |
| inv_asid_any | input | 1 | Range form ignores asid |
| inv_vmid | input | 16 | Invalidation virtual-machine identifier |
| inv_vmid_any | input | 1 | Range form ignores vmid |
| inv_addr | input | 48 | Range base address |
| inv_gran | input | 2 | Range granule code, 0 means 4 KB |
| inv_pages | input | 16 | Range length in granules |
| inv_ttl | input | 2 | Level hint, 0 means none |
| hit_count | output | 32 | Hit counter |
| miss_count | output | 32 | Miss counter |

## Verification
Two collisions can occur in one clock. A level probe can meet an address-space invalidation that removes the slot being probed. An insert can meet an invalidation that names the inserted identifier. The bench provokes the first by raising the invalidation on the clock right after the lookup is accepted, against a slot found on the first probe. It expects a hit response, and then a miss on the next lookup. It provokes the second by driving both strobes on the same clock and expects a later lookup of the new entry to hit.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  parameter int ASID_W = 16;
  parameter int VMID_W = 16;
  parameter int AW     = 48;
  parameter int OW     = 48;
  parameter int PERM_W = 2;
  parameter int PG_W   = 16;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic [AW-1:0]     addr;
    logic [1:0]        gcode;
    logic [1:0]        lvl;
    logic [OW-1:0]     oaddr;
    logic [AW-1:0]     mask;
    logic [PERM_W-1:0] perm;
  } iotlb_entry_t;

  typedef enum logic [1:0] {
    INV_ALL   = 2'd0,
    INV_ASID  = 2'd1,
    INV_VMID  = 2'd2,
    INV_RANGE = 2'd3
  } inv_op_e;

  // log2 of the granule; code 0 is taken as 4 KB
  function automatic int gran_log2(input logic [1:0] g);
    return (g == 2'd0) ? 12 : 10 + 2 * int'(g);
  endfunction

  // address bits covered by one entry at a level
  function automatic logic [6:0] lvl_shift(input logic [1:0] lvl, input logic [1:0] g);
    int gl;
    gl = gran_log2(g);
    return 7'((gl - 3) * (4 - int'(lvl)) + 3);
  endfunction

  function automatic logic [AW-1:0] span_mask(input logic [6:0] sh);
    if (int'(sh) >= AW) return '1;
    return (AW'(1) << sh) - AW'(1);
  endfunction

  function automatic logic [1:0] start_level(input logic [5:0] tsz, input logic [1:0] g);
    int insz;
    int stride;
    int q;
    insz   = 64 - int'(tsz);
    stride = gran_log2(g) - 3;
    q      = (insz < 4) ? 0 : (insz - 4) / stride;
    if (q >= 4) return 2'd0;
    if (q < 1) return 2'd3;
    return 2'(4 - q);
  endfunction
endpackage

// File: rtl/iotlb_probe_cmp.sv
module iotlb_probe_cmp
  import iotlb_pkg::*;
(
  input  iotlb_entry_t      ent,
  input  logic              ent_vld,
  input  logic [ASID_W-1:0] k_asid,
  input  logic [VMID_W-1:0] k_vmid,
  input  logic [AW-1:0]     k_addr,
  input  logic [1:0]        k_gcode,
  input  logic [1:0]        k_lvl,
  output logic              hit
);
  assign hit = ent_vld && (ent.asid == k_asid) && (ent.vmid == k_vmid) &&
               (ent.addr == k_addr) && (ent.gcode == k_gcode) && (ent.lvl == k_lvl);
endmodule

// File: rtl/iotlb_kill_gen.sv
module iotlb_kill_gen
  import iotlb_pkg::*;
#(
  parameter int N = 16
) (
  input  iotlb_entry_t      ents [N],
  input  logic [N-1:0]      vld,
  input  logic              inv_valid,
  input  logic [1:0]        inv_op,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              inv_asid_any,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic              inv_vmid_any,
  input  logic [AW-1:0]     inv_addr,
  input  logic [1:0]        inv_gran,
  input  logic [PG_W-1:0]   inv_pages,
  input  logic [1:0]        inv_ttl,
  output logic [N-1:0]      kill
);
  logic [N-1:0]  by_asid, by_vmid, by_range, by_tag;
  logic [AW-1:0] cmd_mask;
  logic          tag_mode;

  always_comb begin
    cmd_mask = (AW'(inv_pages) << gran_log2(inv_gran)) - AW'(1);
    tag_mode = (inv_ttl != 2'd0) && (inv_pages == PG_W'(1)) && !inv_asid_any && !inv_vmid_any;
    for (int i = 0; i < N; i++) begin
      by_asid[i]  = vld[i] && (ents[i].asid == inv_asid);
      by_vmid[i]  = vld[i] && (ents[i].vmid == inv_vmid);
      by_range[i] = vld[i] && (inv_asid_any || ents[i].asid == inv_asid) &&
                    (inv_vmid_any || ents[i].vmid == inv_vmid) &&
                    (((inv_addr & ~ents[i].mask) == ents[i].addr) ||
                     ((ents[i].addr & ~cmd_mask) == inv_addr));
      by_tag[i]   = by_asid[i] && by_vmid[i] && (ents[i].addr == inv_addr) &&
                    (ents[i].gcode == inv_gran) && (ents[i].lvl == inv_ttl);
    end
    kill = '0;
    if (inv_valid) begin
      case (inv_op)
        INV_ALL:  kill = vld;
        INV_ASID: kill = by_asid;
        INV_VMID: kill = by_vmid;
        default:  kill = (tag_mode && (|by_tag)) ? by_tag : by_range;
      endcase
    end
  end
endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic [AW-1:0]     lk_addr,
  input  logic [1:0]        lk_gran,
  input  logic [5:0]        lk_tsz,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [OW-1:0]     rsp_oaddr,
  output logic [AW-1:0]     rsp_mask,
  output logic [PERM_W-1:0] rsp_perm,
  output logic [1:0]        rsp_level,
  output logic [1:0]        rsp_gran,
  input  logic              ins_valid,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic [VMID_W-1:0] ins_vmid,
  input  logic [AW-1:0]     ins_addr,
  input  logic [1:0]        ins_gran,
  input  logic [1:0]        ins_level,
  input  logic [OW-1:0]     ins_oaddr,
  input  logic [PERM_W-1:0] ins_perm,
  input  logic              inv_valid,
  input  logic [1:0]        inv_op,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              inv_asid_any,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic              inv_vmid_any,
  input  logic [AW-1:0]     inv_addr,
  input  logic [1:0]        inv_gran,
  input  logic [PG_W-1:0]   inv_pages,
  input  logic [1:0]        inv_ttl,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  iotlb_entry_t       ents [ENTRIES];
  logic [ENTRIES-1:0] vld, vld_nxt, kill, phit;

  // lookup key held during the level walk
  logic               busy;
  logic [ASID_W-1:0]  k_asid;
  logic [VMID_W-1:0]  k_vmid;
  logic [AW-1:0]      k_addr;
  logic [1:0]         k_gcode, k_lvl;
  logic [AW-1:0]      probe_addr;
  logic [IDX_W-1:0]   hit_idx, free_idx, wr_idx;
  logic               full;
  iotlb_entry_t       new_ent;

  assign lk_ready   = !busy;
  assign probe_addr = k_addr & ~span_mask(lvl_shift(k_lvl, k_gcode));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    iotlb_probe_cmp u_cmp (
      .ent(ents[g]), .ent_vld(vld[g]),
      .k_asid(k_asid), .k_vmid(k_vmid), .k_addr(probe_addr),
      .k_gcode(k_gcode), .k_lvl(k_lvl), .hit(phit[g])
    );
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (phit[i]) hit_idx = IDX_W'(i);
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  // ---------------- lookup walk ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      k_asid     <= '0;
      k_vmid     <= '0;
      k_addr     <= '0;
      k_gcode    <= '0;
      k_lvl      <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_oaddr  <= '0;
      rsp_mask   <= '0;
      rsp_perm   <= '0;
      rsp_level  <= '0;
      rsp_gran   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (lk_valid) begin
          busy    <= 1'b1;
          k_asid  <= lk_asid;
          k_vmid  <= lk_vmid;
          k_addr  <= lk_addr;
          k_gcode <= lk_gran;
          k_lvl   <= start_level(lk_tsz, lk_gran);
        end
      end else if ((|phit) || (k_lvl == 2'd3)) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_hit   <= |phit;
        if (|phit) begin
          rsp_oaddr <= ents[hit_idx].oaddr;
          rsp_mask  <= ents[hit_idx].mask;
          rsp_perm  <= ents[hit_idx].perm;
          rsp_level <= ents[hit_idx].lvl;
          rsp_gran  <= ents[hit_idx].gcode;
          hit_count <= hit_count + CNT_W'(1);
        end else begin
          rsp_oaddr  <= '0;
          rsp_mask   <= '0;
          rsp_perm   <= '0;
          rsp_level  <= '0;
          rsp_gran   <= '0;
          miss_count <= miss_count + CNT_W'(1);
        end
      end else begin
        k_lvl <= k_lvl + 2'd1;
      end
    end
  end

  // ---------------- maintenance ----------------
  iotlb_kill_gen #(.N(ENTRIES)) u_kill (
    .ents(ents), .vld(vld), .inv_valid(inv_valid), .inv_op(inv_op),
    .inv_asid(inv_asid), .inv_asid_any(inv_asid_any),
    .inv_vmid(inv_vmid), .inv_vmid_any(inv_vmid_any),
    .inv_addr(inv_addr), .inv_gran(inv_gran), .inv_pages(inv_pages),
    .inv_ttl(inv_ttl), .kill(kill)
  );

  always_comb begin
    full          = &vld;
    wr_idx        = full ? '0 : free_idx;
    new_ent.asid  = ins_asid;
    new_ent.vmid  = ins_vmid;
    new_ent.gcode = ins_gran;
    new_ent.lvl   = ins_level;
    new_ent.mask  = span_mask(lvl_shift(ins_level, ins_gran));
    new_ent.addr  = ins_addr & ~new_ent.mask;
    new_ent.oaddr = ins_oaddr;
    new_ent.perm  = ins_perm;
    vld_nxt       = vld & ~kill;
    if (ins_valid) begin
      if (full) vld_nxt = '0;
      vld_nxt[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= vld_nxt;
  end

  // payload store without reset, one write port
  always_ff @(posedge clk) begin
    if (ins_valid) ents[wr_idx] <= new_ent;
  end
endmodule

// File: rtl/iotlb_cache_chk.sv
module iotlb_cache_chk #(
  parameter int N     = 16,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic [N-1:0]     vld,
  input logic             ins_valid,
  input logic             inv_valid,
  input logic [1:0]       inv_op
);
  a_r13_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld == '0) && lk_ready && !rsp_valid && (hit_count == '0) && (miss_count == '0));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r4_ready_at_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> lk_ready);

  a_r11_hit_step: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (hit_count == $past(hit_count) + CNT_W'(1)) && $stable(miss_count));

  a_r11_miss_step: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (miss_count == $past(miss_count) + CNT_W'(1)) && $stable(hit_count));

  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> $stable(hit_count) && $stable(miss_count));

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
    ($past(inv_valid && inv_op == 2'd0 && !ins_valid) && !$past(rst)) |-> (vld == '0));

  a_r5_insert_lands: assert property (@(posedge clk) disable iff (rst)
    ($past(ins_valid) && !$past(rst)) |-> (vld != '0));

  a_r5_full_flush: assert property (@(posedge clk) disable iff (rst)
    ($past(ins_valid && (&vld)) && !$past(rst)) |-> ($countones(vld) == 1));
endmodule

bind iotlb_cache iotlb_cache_chk #(.N(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .hit_count(hit_count), .miss_count(miss_count), .vld(vld),
  .ins_valid(ins_valid), .inv_valid(inv_valid), .inv_op(inv_op)
);

// File: tb/test_iotlb_cache.sv
module test_iotlb_cache;
  import iotlb_pkg::*;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              lk_valid = 0, lk_ready;
  logic [ASID_W-1:0] lk_asid = 0;
  logic [VMID_W-1:0] lk_vmid = 0;
  logic [AW-1:0]     lk_addr = 0;
  logic [1:0]        lk_gran = 1;
  logic [5:0]        lk_tsz = 16;
  logic              rsp_valid, rsp_hit;
  logic [OW-1:0]     rsp_oaddr;
  logic [AW-1:0]     rsp_mask;
  logic [PERM_W-1:0] rsp_perm;
  logic [1:0]        rsp_level, rsp_gran;
  logic              ins_valid = 0;
  logic [ASID_W-1:0] ins_asid = 0;
  logic [VMID_W-1:0] ins_vmid = 0;
  logic [AW-1:0]     ins_addr = 0;
  logic [1:0]        ins_gran = 1, ins_level = 3;
  logic [OW-1:0]     ins_oaddr = 0;
  logic [PERM_W-1:0] ins_perm = 0;
  logic              inv_valid = 0;
  logic [1:0]        inv_op = 0;
  logic [ASID_W-1:0] inv_asid = 0;
  logic              inv_asid_any = 0;
  logic [VMID_W-1:0] inv_vmid = 0;
  logic              inv_vmid_any = 0;
  logic [AW-1:0]     inv_addr = 0;
  logic [1:0]        inv_gran = 0;
  logic [PG_W-1:0]   inv_pages = 0;
  logic [1:0]        inv_ttl = 0;
  logic [31:0]       hit_count, miss_count;

  iotlb_cache i_iotlb_cache (.*);

  int n_chk = 0, n_fail = 0, exp_hits = 0, exp_miss = 0;
  logic r_hit;
  logic [OW-1:0] r_oaddr;
  logic [AW-1:0] r_mask;
  logic [1:0] r_lvl;
  int r_lat;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // issue a lookup, wait for the pulse, record latency in clocks after accept
  task automatic lookup(input logic [15:0] a, input logic [15:0] v, input logic [AW-1:0] addr,
                        input logic [1:0] g, input logic [5:0] tsz);
    @(negedge clk);
    lk_valid = 1; lk_asid = a; lk_vmid = v; lk_addr = addr; lk_gran = g; lk_tsz = tsz;
    @(negedge clk);
    lk_valid = 0;
    r_lat = 0; r_hit = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        r_lat = i; r_hit = rsp_hit; r_oaddr = rsp_oaddr; r_mask = rsp_mask; r_lvl = rsp_level;
        break;
      end
    end
    if (r_hit) exp_hits++; else exp_miss++;
  endtask

  task automatic insert(input logic [15:0] a, input logic [15:0] v, input logic [AW-1:0] addr,
                        input logic [1:0] lvl, input logic [OW-1:0] oa);
    @(negedge clk);
    ins_valid = 1; ins_asid = a; ins_vmid = v; ins_addr = addr; ins_gran = 1;
    ins_level = lvl; ins_oaddr = oa; ins_perm = 2'd3;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic inval(input logic [1:0] op, input logic [15:0] a, input bit aany,
                       input logic [15:0] v, input bit vany, input logic [AW-1:0] addr,
                       input logic [1:0] g, input logic [15:0] pg, input logic [1:0] ttl);
    @(negedge clk);
    inv_valid = 1; inv_op = op; inv_asid = a; inv_asid_any = aany; inv_vmid = v;
    inv_vmid_any = vany; inv_addr = addr; inv_gran = g; inv_pages = pg; inv_ttl = ttl;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic expect_hit(input string req, input logic [AW-1:0] addr, input logic [15:0] a,
                            input logic [1:0] lvl, input int lat);
    lookup(a, 16'd1, addr, 2'd1, 6'd16);
    check(r_hit == 1, req, "hit", r_hit, 1);
    check(r_lvl == lvl, req, "level", r_lvl, lvl);
    check(r_lat == lat, req, "latency", r_lat, lat);
  endtask

  task automatic expect_miss(input string req, input logic [AW-1:0] addr, input logic [15:0] a);
    lookup(a, 16'd1, addr, 2'd1, 6'd16);
    check(r_hit == 0, req, "miss", r_hit, 0);
    check(r_lat == 4, req, "miss latency", r_lat, 4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(lk_ready == 1, "R13", "ready", lk_ready, 1);
    check(rsp_valid == 0, "R13", "rsp_valid", rsp_valid, 0);
    check(hit_count == 0 && miss_count == 0, "R13", "counters", hit_count + miss_count, 0);
    expect_miss("R13", 48'h0, 16'd0);
  endtask

  task automatic t_tag_match();
    insert(16'd1, 16'd1, 48'h1234_5000, 2'd3, 48'hABC000);
    lookup(16'd1, 16'd1, 48'h1234_5678, 2'd1, 6'd16);
    check(r_hit == 1, "R1", "page hit", r_hit, 1);
    check(r_oaddr == 48'hABC000, "R1", "oaddr", r_oaddr, 48'hABC000);
    check(r_mask == 48'hFFF, "R3", "mask", r_mask, 48'hFFF);
    check(r_lat == 4, "R2", "level-3 latency", r_lat, 4);
    lookup(16'd2, 16'd1, 48'h1234_5678, 2'd1, 6'd16);
    check(r_hit == 0, "R1", "asid differs", r_hit, 0);
    lookup(16'd1, 16'd9, 48'h1234_5678, 2'd1, 6'd16);
    check(r_hit == 0, "R1", "vmid differs", r_hit, 0);
    lookup(16'd1, 16'd1, 48'h1234_5678, 2'd3, 6'd16);
    check(r_hit == 0, "R1", "granule differs", r_hit, 0);
    check(r_lat == 3, "R2", "64KB start level 1", r_lat, 3);
  endtask

  task automatic t_block();
    insert(16'd1, 16'd1, 48'h4000_0000, 2'd2, 48'h8000_0000);
    lookup(16'd1, 16'd1, 48'h4012_3456, 2'd1, 6'd16);
    check(r_hit == 1, "R3", "block offset hit", r_hit, 1);
    check(r_mask == 48'h1F_FFFF, "R3", "block mask", r_mask, 48'h1F_FFFF);
    check(r_lat == 3, "R2", "level-2 latency", r_lat, 3);
    @(negedge clk);
    lk_valid = 1; lk_asid = 1; lk_vmid = 1; lk_addr = 48'h4000_0000; lk_gran = 1; lk_tsz = 16;
    @(negedge clk);
    lk_valid = 0;
    check(lk_ready == 0, "R4", "ready low while probing", lk_ready, 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check(rsp_valid == 1 && lk_ready == 1, "R4", "pulse with ready", {rsp_valid, lk_ready}, 2'b11);
    exp_hits++;
    @(negedge clk);
    check(rsp_valid == 0, "R4", "pulse one clock", rsp_valid, 0);
  endtask

  task automatic t_asid_vmid();
    inval(2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_miss("R6", 48'h1234_5000, 16'd1);
    insert(16'd5, 16'd1, 48'h6000, 2'd3, 48'h1);
    insert(16'd6, 16'd1, 48'h7000, 2'd3, 48'h2);
    insert(16'd6, 16'd2, 48'h8000, 2'd3, 48'h3);
    inval(2'd1, 16'd5, 0, 0, 0, 0, 0, 0, 0);
    expect_miss("R7", 48'h6000, 16'd5);
    expect_hit("R7", 48'h7000, 16'd6, 2'd3, 4);
    inval(2'd2, 0, 0, 16'd1, 0, 0, 0, 0, 0);
    expect_miss("R8", 48'h7000, 16'd6);
    lookup(16'd6, 16'd2, 48'h8000, 2'd1, 6'd16);
    check(r_hit == 1, "R8", "other vmid kept", r_hit, 1);
  endtask

  task automatic t_range();
    inval(2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
    insert(16'd7, 16'd1, 48'h1000, 2'd3, 0);
    insert(16'd7, 16'd1, 48'h2000, 2'd3, 0);
    insert(16'd8, 16'd1, 48'h3000, 2'd3, 0);
    inval(2'd3, 0, 1, 16'd1, 0, 48'h2000, 2'd0, 16'd2, 2'd0);
    expect_hit("R9", 48'h1000, 16'd7, 2'd3, 4);
    expect_miss("R9", 48'h2000, 16'd7);
    expect_miss("R9", 48'h3000, 16'd8);
    insert(16'd7, 16'd1, 48'h2000, 2'd3, 0);
    insert(16'd8, 16'd1, 48'h2000, 2'd3, 0);
    inval(2'd3, 16'd7, 0, 0, 1, 48'h2000, 2'd1, 16'd1, 2'd0);
    expect_miss("R9", 48'h2000, 16'd7);
    expect_hit("R9", 48'h2000, 16'd8, 2'd3, 4);
    insert(16'd7, 16'd1, 48'h4000_0000, 2'd2, 0);
    inval(2'd3, 16'd7, 0, 0, 1, 48'h4010_0000, 2'd1, 16'd1, 2'd0);
    expect_miss("R9", 48'h4000_0000, 16'd7);
  endtask

  task automatic t_ttl();
    inval(2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
    insert(16'd3, 16'd1, 48'h5000, 2'd3, 48'hA);
    insert(16'd3, 16'd1, 48'h0, 2'd2, 48'hB);
    inval(2'd3, 16'd3, 0, 16'd1, 0, 48'h5000, 2'd1, 16'd1, 2'd3);
    expect_hit("R10", 48'h5000, 16'd3, 2'd2, 3);
    inval(2'd3, 16'd3, 0, 16'd1, 0, 48'h5000, 2'd1, 16'd1, 2'd3);
    expect_miss("R10", 48'h5000, 16'd3);
  endtask

  task automatic t_full();
    inval(2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) insert(16'h10, 16'd1, 48'(i) << 12, 2'd3, 48'(i));
    expect_hit("R5", 48'h5000, 16'h10, 2'd3, 4);
    expect_hit("R5", 48'hF000, 16'h10, 2'd3, 4);
    insert(16'h11, 16'd1, 48'h10_0000, 2'd3, 48'h77);
    expect_miss("R5", 48'h5000, 16'h10);
    expect_hit("R5", 48'h10_0000, 16'h11, 2'd3, 4);
  endtask

  task automatic t_same_cycle();
    inval(2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
    insert(16'd9, 16'd1, 48'h8000_0000, 2'd1, 48'h5);
    @(negedge clk);
    lk_valid = 1; lk_asid = 9; lk_vmid = 1; lk_addr = 48'h8123_4567; lk_gran = 1; lk_tsz = 25;
    @(negedge clk);
    lk_valid = 0;
    inv_valid = 1; inv_op = 2'd1; inv_asid = 9;
    @(negedge clk);
    inv_valid = 0;
    check(rsp_valid == 1 && rsp_hit == 1, "R12", "probe sees old contents",
          {rsp_valid, rsp_hit}, 2'b11);
    exp_hits++;
    expect_miss("R12", 48'h8000_0000, 16'd9);
    @(negedge clk);
    ins_valid = 1; ins_asid = 9; ins_vmid = 1; ins_addr = 48'h9000; ins_level = 3; ins_gran = 1;
    inv_valid = 1; inv_op = 2'd1; inv_asid = 9;
    @(negedge clk);
    ins_valid = 0; inv_valid = 0;
    expect_hit("R12", 48'h9000, 16'd9, 2'd3, 4);
  endtask

  bit done = 0;
  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_tag_match();
    t_block();
    t_asid_vmid();
    t_range();
    t_ttl();
    t_full();
    t_same_cycle();
    @(negedge clk);
    check(hit_count == 32'(exp_hits), "R11", "hit counter", hit_count, exp_hits);
    check(miss_count == 32'(exp_miss), "R11", "miss counter", miss_count, exp_miss);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule